// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Sequencer

This block steers a linear fetch, decode, execute pipeline. It owns the fetch address, presents it to an instruction memory that answers in the same cycle, and carries each returned 32-bit word with its address through a decode register and then an execute register. Decode logic and the execute datapath (register bank reads, shifter, ALU, writeback) sit outside and consume the stage outputs. They use the valid flags to decide whether the stage holds real work.

In straight-line code, one instruction leaves execute every clock, although each one spends three clocks in flight. The instruction in execute also gets a program-counter value that is eight bytes past its own address. When the execute stage reports a taken branch, the two younger stages are discarded and fetch restarts at the word-aligned target. Execute then stays empty for two clocks while the pipeline refills.

A three-state machine tracks how full the pipeline is. The states are EMPTY (decode and execute both idle), HALF (decode holds work, execute idle) and FULL (both hold work). The transitions are:
- EMPTY to HALF, always.
- HALF to FULL, always.
- FULL to FULL when no taken branch arrives.
- FULL to EMPTY when a taken branch arrives (the flush transition).

Reset enters EMPTY.

Top module: `pipe3_ctl`

## Requirements
- R1: While reset is asserted, imem_addr is 0 and both dec_valid and ex_valid are 0.
- R2: A valid instruction in decode that is not flushed appears in execute on the next clock, with the same word and address.
- R3: Without an effective taken branch, imem_addr advances by 4 every clock.
- R4: While ex_valid is 1, ex_pc_vis equals ex_pc plus 8.
- R5: After reset release with no branches, ex_valid is 1 from the third cycle onward, and execute sees addresses 0, 4, 8, ... on consecutive clocks.
- R6: A br_taken sampled while ex_valid is 1 makes the next cycle's imem_addr equal the target, with dec_valid and ex_valid both 0.
- R7: After an effective taken branch, ex_valid stays 0 for two cycles, and in the third cycle execute holds the target word with ex_pc equal to the aligned target.
- R8: br_taken while ex_valid is 0 has no effect; fetch keeps stepping by 4.
- R9: The pair {dec_valid, ex_valid} only takes the values 00 (EMPTY), 10 (HALF) and 11 (FULL), following the transitions listed above.
- R10: Fetch addresses are word aligned; bits 1:0 of br_target are cleared on a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address to instruction memory |
| imem_data | input | 32 | Word returned for imem_addr in the same cycle |
| br_taken | input | 1 | Execute reports a taken branch |
| br_target | input | 32 | Branch destination address |
| dec_valid | output | 1 | Decode stage holds a live instruction |
| dec_instr | output | 32 | Word in decode |
| dec_pc | output | 32 | Address of the word in decode |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_instr | output | 32 | Word in execute |
| ex_pc | output | 32 | Address of the word in execute |
| ex_pc_vis | output | 32 | PC value seen by the executing instruction (ex_pc + 8) |

## Verification
A wrong fill state shows up within one clock: the valid pair leaves the 00, 10, 11 sequence, or execute shows a word one step early or late. A wrong fetch pointer shows on imem_addr in the very next cycle. It then reaches ex_pc two clocks later. A flush that misses a stage leaks a stale address into execute within two clocks of the branch. A reference model of in-flight addresses is compared against every stage output on every clock, so each of these faults is reported at its first visible cycle.

// File: rtl/pipe3_pkg.sv
`timescale 1ns/1ps
package pipe3_pkg;
    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_HALF  = 2'd1,
        PS_FULL  = 2'd2
    } pipe_state_e;
endpackage

// File: rtl/pipe3_fsm.sv
`timescale 1ns/1ps
module pipe3_fsm
    import pipe3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    output logic dec_valid,
    output logic ex_valid
);
    pipe_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            PS_EMPTY: state_nxt = PS_HALF;
            PS_HALF:  state_nxt = PS_FULL;
            PS_FULL:  state_nxt = flush ? PS_EMPTY : PS_FULL;
            default:  state_nxt = PS_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state)
            PS_EMPTY: begin dec_valid = 1'b0; ex_valid = 1'b0; end
            PS_HALF:  begin dec_valid = 1'b1; ex_valid = 1'b0; end
            PS_FULL:  begin dec_valid = 1'b1; ex_valid = 1'b1; end
            default:  begin dec_valid = 1'b0; ex_valid = 1'b0; end
        endcase
    end

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {PS_EMPTY, PS_HALF, PS_FULL}); // R9
    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_EMPTY) |=> (state == PS_HALF)); // R9
endmodule

// File: rtl/pipe3_fetch.sv
`timescale 1ns/1ps
module pipe3_fetch #(
    parameter int          XLEN     = 32,
    parameter int          STEP     = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] fetch_pc
);
    localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);
    localparam logic [XLEN-1:0] MASK_W = ~XLEN'(STEP - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fetch_pc <= XLEN'(RESET_PC);
        else if (redirect) fetch_pc <= target & MASK_W;
        else               fetch_pc <= fetch_pc + STEP_W;
    end

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_pc[1:0] == 2'b00)); // R10
endmodule

// File: rtl/pipe3_stage.sv
`timescale 1ns/1ps
module pipe3_stage #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] in_instr,
    input  logic [XLEN-1:0] in_pc,
    output logic [XLEN-1:0] out_instr,
    output logic [XLEN-1:0] out_pc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_instr <= '0;
            out_pc    <= '0;
        end else begin
            out_instr <= in_instr;
            out_pc    <= in_pc;
        end
    end
endmodule

// File: rtl/pipe3_ctl.sv
`timescale 1ns/1ps
module pipe3_ctl #(
    parameter int          XLEN        = 32,
    parameter int          INSTR_BYTES = 4,
    parameter logic [31:0] RESET_PC    = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic            dec_valid,
    output logic [XLEN-1:0] dec_instr,
    output logic [XLEN-1:0] dec_pc,
    output logic            ex_valid,
    output logic [XLEN-1:0] ex_instr,
    output logic [XLEN-1:0] ex_pc,
    output logic [XLEN-1:0] ex_pc_vis
);
    localparam int              NSTAGE   = 3;
    localparam int              PC_AHEAD = (NSTAGE - 1) * INSTR_BYTES;
    localparam logic [XLEN-1:0] AHEAD_W  = XLEN'(PC_AHEAD);
    localparam logic [XLEN-1:0] STEP_W   = XLEN'(INSTR_BYTES);

    logic            flush;
    logic [XLEN-1:0] fetch_pc;
    logic [XLEN-1:0] st_instr [NSTAGE];
    logic [XLEN-1:0] st_pc    [NSTAGE];

    assign flush = br_taken & ex_valid;

    pipe3_fetch #(.XLEN(XLEN), .STEP(INSTR_BYTES), .RESET_PC(RESET_PC)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (flush),
        .target   (br_target),
        .fetch_pc (fetch_pc)
    );

    pipe3_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .dec_valid (dec_valid),
        .ex_valid  (ex_valid)
    );

    assign st_instr[0] = imem_data;
    assign st_pc[0]    = fetch_pc;

    for (genvar i = 1; i < NSTAGE; i++) begin : g_stage
        pipe3_stage #(.XLEN(XLEN)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_instr  (st_instr[i-1]),
            .in_pc     (st_pc[i-1]),
            .out_instr (st_instr[i]),
            .out_pc    (st_pc[i])
        );
    end

    assign imem_addr = fetch_pc;
    assign dec_instr = st_instr[1];
    assign dec_pc    = st_pc[1];
    assign ex_instr  = st_instr[2];
    assign ex_pc     = st_pc[2];
    assign ex_pc_vis = st_pc[2] + AHEAD_W;

    AST_DEC_TO_EX: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !flush) |=> (ex_valid && ex_pc == $past(dec_pc) && ex_instr == $past(dec_instr))); // R2
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (imem_addr == $past(imem_addr) + STEP_W)); // R3
    AST_EX_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (imem_addr == ex_pc + AHEAD_W)); // R4
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dec_valid && !ex_valid)); // R6
    AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (imem_addr[XLEN-1:2] == $past(br_target[XLEN-1:2]))); // R6
    AST_IDLE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !ex_valid) |=> (imem_addr == $past(imem_addr) + STEP_W)); // R8
endmodule

// File: tb/pipe3_ctl_test.sv
`timescale 1ns/1ps
module pipe3_ctl_test;
    localparam logic [31:0] BUB = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_data, br_target;
    logic        br_taken;
    logic        dec_valid, ex_valid;
    logic [31:0] dec_instr, dec_pc, ex_instr, ex_pc, ex_pc_vis;

    always #5 clk = ~clk;

    pipe3_ctl uut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .br_taken(br_taken), .br_target(br_target),
        .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc), .ex_pc_vis(ex_pc_vis)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
    endfunction

    assign imem_data = mem_word(imem_addr);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] slot[$];
    logic [31:0] m_fpc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit dv, ev;
        dv = (slot[0] != BUB);
        ev = (slot[1] != BUB);
        chk("R3 fetch address", imem_addr, m_fpc);
        chk("R9 valid pair", {30'd0, dec_valid, ex_valid}, {30'd0, dv, ev});
        if (dv) begin
            chk("R2 decode address", dec_pc, slot[0]);
            chk("R2 decode word", dec_instr, mem_word(slot[0]));
        end
        if (ev) begin
            chk("R2 execute address", ex_pc, slot[1]);
            chk("R2 execute word", ex_instr, mem_word(slot[1]));
            chk("R4 visible pc", ex_pc_vis, slot[1] + 32'd8);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int          bk;
        int          n_early;
        logic [31:0] btgt;
        logic [15:0] lfsr;
        bit          take, eff;
        logic [31:0] tgt;

        rst_n = 1'b0; br_taken = 1'b0; br_target = '0;
        bk = -100; btgt = '0; n_early = 0; lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset fetch address", imem_addr, 32'h0);
        chk("R1 reset decode valid", {31'd0, dec_valid}, 32'd0);
        chk("R1 reset execute valid", {31'd0, ex_valid}, 32'd0);
        rst_n = 1'b1;
        slot = '{BUB, BUB};
        m_fpc = 32'h0;

        for (int k = 0; k < 400; k++) begin
            compare_all();
            if (k < 20 && ex_valid) begin
                n_early++;
                chk("R5 straight-line execute address", ex_pc, 32'(4 * (k - 2)));
            end
            if (k == 20) chk("R5 completions in first 20 cycles", 32'(n_early), 32'd18);
            if (k == bk + 1) begin
                chk("R6 fetch restarts at target", imem_addr, btgt);
                chk("R6 stages cleared", {30'd0, dec_valid, ex_valid}, 32'd0);
            end
            if (k == bk + 1 || k == bk + 2)
                chk("R7 execute idle during refill", {31'd0, ex_valid}, 32'd0);
            if (k == bk + 3) begin
                chk("R7 refill execute valid", {31'd0, ex_valid}, 32'd1);
                chk("R7 refill execute address", ex_pc, btgt);
            end
            if (k == 22) chk("R8 idle branch ignored", imem_addr, 32'h104);
            if (k == 31) chk("R10 aligned redirect", imem_addr, 32'h200);

            take = 1'b0; tgt = '0;
            case (k)
                20: begin take = 1'b1; tgt = 32'h100;  end
                21: begin take = 1'b1; tgt = 32'h5550; end
                30: begin take = 1'b1; tgt = 32'h203;  end
                33: begin take = 1'b1; tgt = 32'h40;   end
                default: begin
                    if (k > 40) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        if (lfsr[2:0] == 3'b101) begin
                            take = 1'b1;
                            tgt  = {16'h0, lfsr[15:3], 3'b011};
                        end
                    end
                end
            endcase
            br_taken  = take;
            br_target = tgt;
            eff = take && (slot[1] != BUB);
            if (eff) begin
                bk   = k;
                btgt = tgt & 32'hFFFF_FFFC;
            end

            @(posedge clk);
            if (eff) begin
                slot  = '{BUB, BUB};
                m_fpc = tgt & 32'hFFFF_FFFC;
            end else begin
                slot.push_front(m_fpc);
                void'(slot.pop_back());
                m_fpc = m_fpc + 32'd4;
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule